// File: doc/BRIEF.md
# Security Monitor State Machine

This block decides whether the cipher engine beside it may run, and which class of key that engine uses. After reset it passes through a start state and a timed memory-wipe phase. It then waits in a health-check state until software proves the sequence checker works. Software does this by writing three fixed patterns in a fixed order. A correct sequence puts the monitor in the secure state, where the secret key is selected. Any wrong value or wrong order puts it in the non-secure state, where the default key is used. A software alarm or the tamper pin sends the monitor to a locked fail state from anywhere. In fail the cipher engine is held off until the next reset.

Software reaches the block through a small write-only port with four word addresses. The 5-bit state code, a sticky interrupt flag, the cipher enable, the key select and a bit-bank clear strobe are all available as pins.

Top module: `secmon_top`

## Requirements
- R1: `state_o` carries a sparse 5-bit code: 0x00 start, 0x05 memory wipe, 0x06 health check, 0x09 fail, 0x0A secure, 0x0C non-secure. During reset and up to the first clock edge after reset it reads 0x00, with `irq_o`, `cipher_en_o` and `key_secret_o` low.
- R2: After reset the state moves from start to memory wipe on the first edge. It stays in memory wipe for exactly ZERO_WORDS cycles and then enters health check.
- R3: In health check, three writes complete the sequence: 0xAAAA to address 1 (sequence start), then 0x5555 to address 2 (sequence end), then 0x5555 to address 3 (sequence check). Writes to address 0 may come between them. The state reads secure from the edge that captures the third write.
- R4: In health check, a write to address 1, 2 or 3 whose address or value is not the next one expected moves the state to non-secure on the edge that captures it.
- R5: `cipher_en_o` is high only in secure and non-secure. `key_secret_o` is high only in secure.
- R6: A write to address 0 with bit 0 set, or `tamper_i` high at a clock edge, moves the state to fail on that edge from any state.
- R7: Fail is left only by reset. Later writes of any kind and tamper pulses leave it at 0x09.
- R8: A state change sets `irq_o` on the same edge if the interrupt enable was set before that edge. `irq_o` stays set until a write to address 0 with bit 3 set. If a state change and a clear arrive on the same edge, the set wins.
- R9: Each write to address 0 loads the interrupt enable from bit 1. Once a write to address 0 carries bit 4, later writes no longer change the enable until reset. The enable is 0 after reset.
- R10: A write to address 0 with bit 2 set raises `bitbank_clr_o` for the one cycle that follows the capturing edge.
- R11: Writes to addresses 1 to 3 have no effect outside health check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 command, 1 sequence start, 2 sequence end, 3 sequence check |
| wr_data | input | DATA_W | Write data |
| tamper_i | input | 1 | Tamper alarm, level sampled each edge |
| state_o | output | 5 | Current state code |
| irq_o | output | 1 | Sticky interrupt flag |
| cipher_en_o | output | 1 | Cipher engine allowed to run |
| key_secret_o | output | 1 | 1 selects the secret key, 0 the default key |
| bitbank_clr_o | output | 1 | One-cycle bit-bank clear strobe |

## Verification
The properties assume that the write strobe, address, data and tamper pin are never unknown once reset is released. They also assume that each write lasts exactly one clock cycle. The bench changes every input only on the falling edge and returns the strobe to zero after one cycle. Corrupted sequence writes are built so that they always differ from the expected word in either address or value, which keeps the expected outcome unambiguous. Alarms are raised only through a command write or a one-cycle tamper pulse.

// File: rtl/secmon_pkg.sv
package secmon_pkg;

  typedef enum logic [4:0] {
    MS_START  = 5'h00,
    MS_WIPE   = 5'h05,
    MS_HEALTH = 5'h06,
    MS_FAIL   = 5'h09,
    MS_SECURE = 5'h0A,
    MS_NONSEC = 5'h0C
  } mon_state_e;

  localparam logic [1:0] A_CMD   = 2'd0;
  localparam logic [1:0] A_SQBEG = 2'd1;
  localparam logic [1:0] A_SQEND = 2'd2;
  localparam logic [1:0] A_SQCHK = 2'd3;

  localparam int CB_ALARM = 0;
  localparam int CB_IEN   = 1;
  localparam int CB_BBCLR = 2;
  localparam int CB_ICLR  = 3;
  localparam int CB_LOCK  = 4;

  localparam int SEQ_LAST = 2;

  // address that step n of the unlock sequence must hit
  function automatic logic [1:0] seq_addr(input logic [1:0] step);
    return step + 2'd1;
  endfunction

  // pattern that step n of the unlock sequence must carry
  function automatic logic [15:0] seq_word(input logic [1:0] step);
    return (step == 2'd0) ? 16'hAAAA : 16'h5555;
  endfunction

endpackage

// File: rtl/secmon_seqchk.sv
module secmon_seqchk
  import secmon_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              seq_pass,
  output logic              seq_fail
);

  logic [1:0] step_q;
  logic       seq_wr;
  logic       hit;

  assign seq_wr   = wr_en && active && (wr_addr != A_CMD);
  assign hit      = seq_wr && (wr_addr == seq_addr(step_q)) &&
                    (wr_data == DATA_W'(seq_word(step_q)));
  assign seq_pass = hit && (step_q == 2'(SEQ_LAST));
  assign seq_fail = seq_wr && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    step_q <= 2'd0;
    else if (!active)              step_q <= 2'd0;
    else if (seq_fail || seq_pass) step_q <= 2'd0;
    else if (hit)                  step_q <= step_q + 2'd1;
  end

endmodule

// File: rtl/secmon_fsm.sv
module secmon_fsm
  import secmon_pkg::*;
#(
  parameter int ZERO_WORDS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alarm,
  input  logic       seq_pass,
  input  logic       seq_fail,
  output mon_state_e state_q,
  output logic       state_chg,
  output logic       wipe_done
);

  localparam int CW = (ZERO_WORDS > 1) ? $clog2(ZERO_WORDS) : 1;
  localparam logic [CW-1:0] WIPE_LAST = CW'(ZERO_WORDS - 1);

  mon_state_e    nxt;
  logic [CW-1:0] wcnt_q;

  assign wipe_done = (state_q == MS_WIPE) && (wcnt_q == WIPE_LAST);

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      MS_START:  nxt = MS_WIPE;
      MS_WIPE:   if (wipe_done) nxt = MS_HEALTH;
      MS_HEALTH: begin
        if (seq_pass)      nxt = MS_SECURE;
        else if (seq_fail) nxt = MS_NONSEC;
      end
      default:   nxt = state_q;
    endcase
    if (alarm) nxt = MS_FAIL;
  end

  assign state_chg = (nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_START;
      wcnt_q  <= '0;
    end else begin
      state_q <= nxt;
      wcnt_q  <= (state_q == MS_WIPE && !wipe_done) ? wcnt_q + CW'(1) : '0;
    end
  end

endmodule

// File: rtl/secmon_ctl.sv
module secmon_ctl
  import secmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [4:0] cmd_bits,
  input  logic       state_chg,
  output logic       ien_q,
  output logic       irq_q,
  output logic       bb_q,
  output logic       clr_req
);

  logic lock_q;

  assign clr_req = cmd_wr && cmd_bits[CB_ICLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
      bb_q   <= 1'b0;
    end else begin
      if (cmd_wr && !lock_q)          ien_q  <= cmd_bits[CB_IEN];
      if (cmd_wr && cmd_bits[CB_LOCK]) lock_q <= 1'b1;
      if (state_chg && ien_q)         irq_q  <= 1'b1;
      else if (clr_req)               irq_q  <= 1'b0;
      bb_q <= cmd_wr && cmd_bits[CB_BBCLR];
    end
  end

endmodule

// File: rtl/secmon_top.sv
module secmon_top
  import secmon_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ZERO_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tamper_i,
  output logic [4:0]        state_o,
  output logic              irq_o,
  output logic              cipher_en_o,
  output logic              key_secret_o,
  output logic              bitbank_clr_o
);

  mon_state_e st;
  logic       cmd_wr;
  logic       alarm_req;
  logic       seq_pass;
  logic       seq_fail;
  logic       state_chg;
  logic       wipe_done;
  logic       ien_q;
  logic       clr_req;

  assign cmd_wr    = wr_en && (wr_addr == A_CMD);
  assign alarm_req = (cmd_wr && wr_data[CB_ALARM]) || tamper_i;

  secmon_seqchk #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(st == MS_HEALTH),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seq_pass(seq_pass), .seq_fail(seq_fail)
  );

  secmon_fsm #(.ZERO_WORDS(ZERO_WORDS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .alarm(alarm_req),
    .seq_pass(seq_pass), .seq_fail(seq_fail),
    .state_q(st), .state_chg(state_chg), .wipe_done(wipe_done)
  );

  secmon_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bits(wr_data[4:0]),
    .state_chg(state_chg), .ien_q(ien_q), .irq_q(irq_o),
    .bb_q(bitbank_clr_o), .clr_req(clr_req)
  );

  assign state_o      = st;
  assign cipher_en_o  = (st == MS_SECURE) || (st == MS_NONSEC);
  assign key_secret_o = (st == MS_SECURE);

endmodule

// File: rtl/secmon_chk.sv
module secmon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [4:0] cmd_bits,
  input logic       alarm_req,
  input logic       seq_pass,
  input logic       seq_fail,
  input logic       ien_q,
  input logic       clr_req,
  input logic [4:0] state_o,
  input logic       irq_o,
  input logic       cipher_en_o,
  input logic       key_secret_o,
  input logic       bitbank_clr_o
);

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_o inside {5'h00, 5'h05, 5'h06, 5'h09, 5'h0A, 5'h0C});

  a_r2_start_to_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 5'h00 && !alarm_req) |=> state_o == 5'h05);

  a_r3_pass_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 5'h06 && seq_pass && !alarm_req) |=> state_o == 5'h0A);

  a_r4_miss_nonsec: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 5'h06 && seq_fail && !alarm_req) |=> state_o == 5'h0C);

  a_r5_key_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    key_secret_o |-> cipher_en_o);

  a_r5_fail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 5'h09) |-> !cipher_en_o);

  a_r6_alarm_fail: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_req |=> state_o == 5'h09);

  a_r7_fail_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 5'h09) |=> state_o == 5'h09);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_req) |=> irq_o);

  a_r8_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q && !$stable(state_o)) |-> irq_o);

  a_r10_bb_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_bits[2]) |=> bitbank_clr_o);

endmodule

bind secmon_top secmon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bits(wr_data[4:0]),
  .alarm_req(alarm_req), .seq_pass(seq_pass), .seq_fail(seq_fail),
  .ien_q(u_ctl.ien_q), .clr_req(clr_req), .state_o(state_o), .irq_o(irq_o),
  .cipher_en_o(cipher_en_o), .key_secret_o(key_secret_o),
  .bitbank_clr_o(bitbank_clr_o)
);

// File: tb/sim_secmon_top.sv
`timescale 1ns/1ps
module sim_secmon_top;

  localparam int NW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tamper_i = 1'b0;
  logic [4:0]  state_o;
  logic        irq_o, cipher_en_o, key_secret_o, bitbank_clr_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  secmon_top #(.DATA_W(16), .ZERO_WORDS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tamper_i(tamper_i), .state_o(state_o),
    .irq_o(irq_o), .cipher_en_o(cipher_en_o), .key_secret_o(key_secret_o),
    .bitbank_clr_o(bitbank_clr_o)
  );

  function automatic logic [1:0] b_addr(input int i);
    return 2'(i + 1);
  endfunction

  function automatic logic [15:0] b_word(input int i);
    return (i == 0) ? 16'hAAAA : 16'h5555;
  endfunction

  function automatic int first_bad(input logic [1:0] a [3], input logic [15:0] d [3]);
    for (int i = 0; i < 3; i++)
      if (a[i] != b_addr(i) || d[i] != b_word(i)) return i;
    return 3;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tamper_pulse();
    @(negedge clk);
    tamper_i = 1'b1;
    @(negedge clk);
    tamper_i = 1'b0;
  endtask

  task automatic do_reset(input bit to_health);
    int zc;
    rst_n = 1'b0; wr_en = 1'b0; tamper_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset irq", irq_o, 0);
    chk("R1 reset cipher", cipher_en_o, 0);
    rst_n = 1'b1;
    chk("R1 start after release", state_o, 0);
    if (to_health) begin
      zc = 0;
      @(negedge clk);
      while (state_o == 5'h05 && zc < 1000) begin zc++; @(negedge clk); end
      chk("R2 wipe length", zc, NW);
      chk("R2 health entry", state_o, 6);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0]  a [3];
    logic [15:0] d [3];
    int bad, ien, expst;
    void'($urandom(32'h5EC0));

    // directed: tamper during wipe
    do_reset(1'b0);
    repeat (3) @(negedge clk);
    chk("R2 in wipe", state_o, 5);
    tamper_pulse();
    chk("R6 tamper in wipe", state_o, 9);
    chk("R5 fail no cipher", cipher_en_o, 0);

    // directed: enable off gives no irq, bitbank strobe, alarm in health
    do_reset(1'b1);
    wr(2'd0, 16'h0004);
    chk("R10 strobe high", bitbank_clr_o, 1);
    @(negedge clk);
    chk("R10 strobe one cycle", bitbank_clr_o, 0);
    wr(2'd1, 16'hAAAA); wr(2'd2, 16'h5555); wr(2'd3, 16'h5555);
    chk("R3 secure", state_o, 10);
    chk("R9 enable off no irq", irq_o, 0);
    chk("R5 secret key", key_secret_o, 1);
    wr(2'd1, 16'h1234);
    chk("R11 ignored outside health", state_o, 10);

    // directed: lock keeps enable
    do_reset(1'b1);
    wr(2'd0, 16'h0012);
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'hAAAA); wr(2'd2, 16'h0000);
    chk("R4 wrong value", state_o, 12);
    chk("R9 locked enable irq", irq_o, 1);
    chk("R5 default key", key_secret_o, 0);
    wr(2'd0, 16'h0001);
    chk("R6 alarm", state_o, 9);
    tamper_pulse(); wr(2'd0, 16'h0008); wr(2'd1, 16'hAAAA);
    chk("R7 fail terminal", state_o, 9);

    // constrained random trials
    for (int t = 0; t < 40; t++) begin
      do_reset(1'b1);
      ien = int'($urandom % 2);
      wr(2'd0, ien ? 16'h0002 : 16'h0000);
      for (int i = 0; i < 3; i++) begin
        a[i] = b_addr(i); d[i] = b_word(i);
        if ($urandom % 4 == 0) begin
          if ($urandom % 2) a[i] = 2'(((i + 1) % 3) + 1);
          else d[i] = d[i] ^ 16'(1 + $urandom % 16'hFFFE);
        end
      end
      bad = first_bad(a, d);
      expst = (bad == 3) ? 10 : 12;
      for (int i = 0; i < 3; i++) begin
        if ($urandom % 3 == 0) wr(2'd0, ien ? 16'h0002 : 16'h0000);
        wr(a[i], d[i]);
        if (i < bad && i < 2) chk("R3 still health", state_o, 6);
        if (i == ((bad < 2) ? bad : 2)) begin
          chk(bad == 3 ? "R3 outcome" : "R4 outcome", state_o, expst);
          chk("R8 irq on change", irq_o, ien);
          chk("R5 cipher run", cipher_en_o, 1);
          chk("R5 key class", key_secret_o, bad == 3);
        end
      end
      chk("R11 state held", state_o, expst);
      wr(2'd0, ien ? 16'h000A : 16'h0008);
      chk("R8 irq cleared", irq_o, 0);
      if ($urandom % 2) tamper_pulse();
      else wr(2'd0, ien ? 16'h0003 : 16'h0001);
      chk("R6 fault to fail", state_o, 9);
      chk("R8 irq on fail", irq_o, ien);
      chk("R5 fail blocks", cipher_en_o, 0);
      wr(2'd1, 16'hAAAA); wr(2'd0, 16'h0002);
      repeat (2) @(negedge clk);
      chk("R7 fail held", state_o, 9);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule